// File: doc/BRIEF.md
# Flash program and erase sequencer

This block sits on the host side of an asynchronous byte-wide flash device and turns one request into the complete bus conversation that the device expects. It drives active-low chip enable, write enable and output enable, an address bus, and a data bus that is split into an output half, an output enable and an input half. A request asks for one of three operations: program a run of consecutive bytes, erase the sector that holds a given address, or erase the whole device.

For each operation the sequencer first issues the unlock and command write cycles. It then reads the device repeatedly until the device reports that its internal algorithm has finished. The status reads follow one of two rules, chosen per request: compare DQ7 with the value the operation should leave there, or take reads in pairs and wait until DQ6 stops changing. When the device reports that it has finished, the sequencer takes one more read to capture a settled byte. For a multi-byte program it then moves to the next address and starts the whole sequence again. The write timing is set by clock-count parameters. A poll counter ends an operation that never finishes and reports it as an error.

Program data comes from the host through a combinational fetch port: the block shows the index of the byte it needs, and the host returns that byte in the same cycle.

Top module: `flash_prog_ctl`

## Requirements
- R1: A program request (req_op = 0) issues, for each byte, four write cycles in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the target address with the data byte.
- R2: A chip erase request (req_op = 2, and also req_op = 3) issues six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h.
- R3: A sector erase request (req_op = 1) issues the same first five write cycles as R2, then a sixth cycle that carries req_addr with data 30h.
- R4: In every write cycle, write enable is low for at least WE_LOW clocks. Output enable stays high and the data output enable stays on while write enable is low. Address and data do not change from the clock where write enable falls until at least one clock after it rises.
- R5: When req_toggle = 0, a program operation keeps the programmed address on the bus for every status read and treats the byte as finished once DQ7 equals bit 7 of the written byte.
- R6: When req_toggle = 0, an erase operation polls at req_addr and treats the erase as finished once DQ7 reads 1.
- R7: When req_toggle = 1, status reads come in pairs, and the operation is finished once DQ6 holds the same value in both reads of a pair.
- R8: After the finish condition is seen, one further read is made, and done_byte reports the value from that read, not the value from any status read.
- R9: A program request writes req_last+1 bytes, at req_addr, req_addr+1, and so on. Byte k is the value on pg_byte while pg_idx = k.
- R10: If POLL_MAX status attempts in a row fail the finish test, the operation ends with err = 1, and the block returns to idle without issuing further writes. In DQ7 mode each single read counts as one attempt.
- R11: req_ready is high only while the block is idle. Each request ends with done high for exactly one clock, and err = 0 when the operation finished normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_toggle | input | 1 | 1 selects DQ6 pair polling, 0 selects DQ7 polling |
| req_addr | input | AW | Start address, or an address inside the sector |
| req_last | input | LW | Index of the last byte to program |
| pg_idx | output | LW | Index of the program byte wanted |
| pg_byte | input | 8 | Program byte for pg_idx, supplied combinationally |
| done | output | 1 | One-clock end-of-request pulse |
| err | output | 1 | Timeout status, valid with done |
| done_byte | output | 8 | Byte from the final read |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Data returned by the flash |

## Verification
The bench runs a behavioural flash model that stays busy for a chosen number of status reads. On the first read after it finishes, DQ7 (and DQ6) are already final but the low bits are still wrong. A design that skipped the final read would therefore report a corrupted done_byte. A design that tested the wrong polarity for programmed bytes whose bit 7 is 0 or 1 would either stop early or never stop.

The model flips DQ6 only on reads it makes while busy, so a pair-polling design that compared the wrong bit would time out. A design that moved the address during program polls is caught by the model's address check.

A request that never finishes checks that the error is raised after exactly POLL_MAX reads. A later request then shows that the block came back to idle.

// File: rtl/flash_ctl_pkg.sv
// Shared types and command codes for the flash sequencer.
// Assumes the unlock addresses fit in the low 15 address bits.
package flash_ctl_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_CHIP_ALT = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL_A,
        ST_POLL_B,
        ST_FINAL,
        ST_DONE
    } seq_e;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_SET,
        BC_ACT,
        BC_END
    } bus_e;

    localparam logic [14:0] UNLOCK_A1 = 15'h5555;
    localparam logic [14:0] UNLOCK_A2 = 15'h2AAA;
    localparam logic [7:0]  KEY_1     = 8'hAA;
    localparam logic [7:0]  KEY_2     = 8'h55;
    localparam logic [7:0]  CODE_PROG = 8'hA0;
    localparam logic [7:0]  CODE_ERS  = 8'h80;
    localparam logic [7:0]  CODE_CHIP = 8'h10;
    localparam logic [7:0]  CODE_SECT = 8'h30;

endpackage

// File: rtl/flash_cmd_gen.sv
// Command step table: maps operation and step index to the address/data
// of one write cycle and flags the final step. Purely combinational.
// Assumes AW >= 15.
module flash_cmd_gen
    import flash_ctl_pkg::*;
#(
    parameter int AW = 18
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] target,
    input  logic [7:0]    pbyte,
    output logic [AW-1:0] cmd_addr,
    output logic [7:0]    cmd_data,
    output logic          cmd_last
);
    localparam logic [AW-1:0] A1 = {{(AW-15){1'b0}}, UNLOCK_A1};
    localparam logic [AW-1:0] A2 = {{(AW-15){1'b0}}, UNLOCK_A2};

    logic is_prog;
    assign is_prog = (op == OP_PROG);

    // Select address and data of the current step.
    always_comb begin
        cmd_addr = A1;
        cmd_data = KEY_1;
        case (step)
            3'd0: begin cmd_addr = A1; cmd_data = KEY_1; end
            3'd1: begin cmd_addr = A2; cmd_data = KEY_2; end
            3'd2: begin cmd_addr = A1; cmd_data = is_prog ? CODE_PROG : CODE_ERS; end
            3'd3: begin
                cmd_addr = is_prog ? target : A1;
                cmd_data = is_prog ? pbyte  : KEY_1;
            end
            3'd4: begin cmd_addr = A2; cmd_data = KEY_2; end
            default: begin
                cmd_addr = (op == OP_SECT) ? target    : A1;
                cmd_data = (op == OP_SECT) ? CODE_SECT : CODE_CHIP;
            end
        endcase
    end

    assign cmd_last = is_prog ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/flash_bus_cycle.sv
// One asynchronous bus cycle per go pulse: a write with a timed
// write-enable pulse or a read with a timed output-enable window.
// Pins are registered. fin pulses once when the cycle is over.
// Assumes go is only raised while the unit is idle and fin is low.
module flash_bus_cycle
    import flash_ctl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int WE_LOW  = 3,
    parameter int WE_HIGH = 2,
    parameter int RD_LOW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          fin,
    output logic [7:0]    rdata,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_i
);
    localparam int MAX_WH = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
    localparam int MAXC   = (MAX_WH > RD_LOW) ? MAX_WH : RD_LOW;
    localparam int CW     = $clog2(MAXC + 1);

    bus_e          bst;
    logic [CW-1:0] cnt;
    logic          wr_q;

    // Phase sequencer for the pins of one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst      <= BC_IDLE;
            cnt      <= '0;
            wr_q     <= 1'b0;
            fin      <= 1'b0;
            rdata    <= '0;
            fl_ce_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_addr  <= '0;
            fl_dq_o  <= '0;
            fl_dq_oe <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (bst)
                BC_IDLE: if (go) begin
                    fl_addr  <= addr;
                    fl_dq_o  <= wdata;
                    fl_dq_oe <= wr;
                    wr_q     <= wr;
                    fl_ce_n  <= 1'b0;
                    bst      <= BC_SET;
                end
                BC_SET: begin
                    if (wr_q) fl_we_n <= 1'b0;
                    else      fl_oe_n <= 1'b0;
                    cnt <= wr_q ? CW'(WE_LOW - 1) : CW'(RD_LOW - 1);
                    bst <= BC_ACT;
                end
                BC_ACT: begin
                    if (cnt == '0) begin
                        fl_we_n <= 1'b1;
                        fl_oe_n <= 1'b1;
                        if (!wr_q) rdata <= fl_dq_i;
                        cnt <= wr_q ? CW'(WE_HIGH - 1) : '0;
                        bst <= BC_END;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        fl_ce_n  <= 1'b1;
                        fl_dq_oe <= 1'b0;
                        fin      <= 1'b1;
                        bst      <= BC_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_prog_ctl.sv
// Top: accepts program/erase requests, runs the command writes, polls
// status (DQ7 compare or DQ6 pair), takes a final read, loops over the
// bytes of a program and times out after POLL_MAX failed attempts.
// Assumes pg_byte follows pg_idx combinationally and LW <= AW.
module flash_prog_ctl
    import flash_ctl_pkg::*;
#(
    parameter int AW       = 18,
    parameter int LW       = 8,
    parameter int WE_LOW   = 3,
    parameter int WE_HIGH  = 2,
    parameter int RD_LOW   = 2,
    parameter int POLL_MAX = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_toggle,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_last,
    output logic [LW-1:0] pg_idx,
    input  logic [7:0]    pg_byte,
    output logic          done,
    output logic          err,
    output logic [7:0]    done_byte,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_i
);
    localparam int PCW = $clog2(POLL_MAX + 1);

    seq_e           st;
    op_e            op_q;
    logic           tgl_q;
    logic [AW-1:0]  base_q;
    logic [LW-1:0]  last_q;
    logic [LW-1:0]  idx_q;
    logic [2:0]     step_q;
    logic [7:0]     byte_q;
    logic [PCW-1:0] poll_q;
    logic           dq6_q;
    logic           wait_q;

    logic           go, fin;
    logic [7:0]     rd;
    logic [AW-1:0]  cur_addr, cg_addr;
    logic [7:0]     cg_data;
    logic           cg_last;
    logic           exp7, poll_out;

    assign cur_addr  = base_q + AW'(idx_q);
    assign pg_idx    = idx_q;
    assign req_ready = (st == ST_IDLE);
    assign go        = (st != ST_IDLE) && (st != ST_DONE) && !wait_q;
    assign exp7      = (op_q == OP_PROG) ? byte_q[7] : 1'b1;
    assign poll_out  = (poll_q == PCW'(POLL_MAX - 1));

    flash_cmd_gen #(.AW(AW)) cg_i (
        .op(op_q), .step(step_q), .target(cur_addr), .pbyte(pg_byte),
        .cmd_addr(cg_addr), .cmd_data(cg_data), .cmd_last(cg_last)
    );

    flash_bus_cycle #(
        .AW(AW), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_LOW(RD_LOW)
    ) bc_i (
        .clk(clk), .rst_n(rst_n), .go(go), .wr(st == ST_CMD),
        .addr((st == ST_CMD) ? cg_addr : cur_addr), .wdata(cg_data),
        .fin(fin), .rdata(rd),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
        .fl_dq_i(fl_dq_i)
    );

    // Request sequencing: command steps, polling, final read, byte loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            op_q      <= OP_PROG;
            tgl_q     <= 1'b0;
            base_q    <= '0;
            last_q    <= '0;
            idx_q     <= '0;
            step_q    <= '0;
            byte_q    <= '0;
            poll_q    <= '0;
            dq6_q     <= 1'b0;
            wait_q    <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            done_byte <= '0;
        end else begin
            done <= 1'b0;
            if (go) wait_q <= 1'b1;
            if (go && st == ST_CMD) byte_q <= pg_byte;
            if (fin) wait_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    tgl_q  <= req_toggle;
                    base_q <= req_addr;
                    last_q <= req_last;
                    idx_q  <= '0;
                    step_q <= '0;
                    err    <= 1'b0;
                    st     <= ST_CMD;
                end
                ST_CMD: if (fin) begin
                    if (cg_last) begin
                        step_q <= '0;
                        poll_q <= '0;
                        st     <= ST_POLL_A;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_POLL_A: if (fin) begin
                    if (tgl_q) begin
                        dq6_q <= rd[6];
                        st    <= ST_POLL_B;
                    end else if (rd[7] == exp7) begin
                        st <= ST_FINAL;
                    end else if (poll_out) begin
                        err <= 1'b1;
                        st  <= ST_DONE;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                    end
                end
                ST_POLL_B: if (fin) begin
                    if (rd[6] == dq6_q) begin
                        st <= ST_FINAL;
                    end else if (poll_out) begin
                        err <= 1'b1;
                        st  <= ST_DONE;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                        st     <= ST_POLL_A;
                    end
                end
                ST_FINAL: if (fin) begin
                    done_byte <= rd;
                    if (op_q != OP_PROG || idx_q == last_q) begin
                        st <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st    <= ST_CMD;
                    end
                end
                default: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_prog_ctl_chk.sv
// Checker for the flash sequencer pins and handshake, bound to the top.
// Assumes synchronous active-low reset; counts write-enable low time.
module flash_prog_ctl_chk #(
    parameter int AW     = 18,
    parameter int WE_LOW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_o,
    input logic          fl_dq_oe,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done
);
    logic [7:0] low_cnt;

    // Count consecutive clocks with write enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (!fl_we_n)     low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 1'b1;
        else                   low_cnt <= '0;
    end

    AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_cnt >= 8'(WE_LOW))); // R4
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && fl_dq_oe && !fl_ce_n)); // R4
    AST_ADDR_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dq_o))); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |=> ($stable(fl_addr) && !fl_ce_n)); // R4
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && fl_we_n && !fl_ce_n)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R11

endmodule

bind flash_prog_ctl flash_prog_ctl_chk #(.AW(AW), .WE_LOW(WE_LOW)) chk_i (
    .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .req_valid(req_valid), .req_ready(req_ready),
    .done(done)
);

// File: tb/flash_prog_ctl_tb_top.sv
// Bench: behavioural flash model plus a scoreboard of expected write cycles.
module flash_prog_ctl_tb_top;
    localparam int AW = 18;
    localparam int LW = 8;
    localparam int WL = 3;
    localparam int PM = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic          req_toggle = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_last = '0;
    logic [LW-1:0] pg_idx;
    logic [7:0]    pg_byte;
    logic          done, err;
    logic [7:0]    done_byte;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_o;
    logic [7:0]    rd_val = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [LW-1:0] i);
        return 8'h36 ^ (8'(i) * 8'hA5);
    endfunction

    assign pg_byte = pat(pg_idx);

    flash_prog_ctl #(.AW(AW), .LW(LW), .WE_LOW(WL), .POLL_MAX(PM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_toggle(req_toggle), .req_addr(req_addr),
        .req_last(req_last), .pg_idx(pg_idx), .pg_byte(pg_byte),
        .done(done), .err(err), .done_byte(done_byte),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
        .fl_dq_i(rd_val)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard queue of expected write cycles.
    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    d;
        string         tag;
    } wr_t;
    wr_t exp_q[$];

    task automatic push(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        wr_t w;
        w.a = a; w.d = d; w.tag = tag;
        exp_q.push_back(w);
    endtask

    task automatic push_prog(input logic [AW-1:0] base, input logic [LW-1:0] last);
        for (int i = 0; i <= int'(last); i++) begin
            push(18'h05555, 8'hAA, "R1");
            push(18'h02AAA, 8'h55, "R1");
            push(18'h05555, 8'hA0, "R1");
            push(base + AW'(i), pat(LW'(i)), "R9");
        end
    endtask

    task automatic push_erase(input bit sect, input logic [AW-1:0] a);
        string t;
        t = sect ? "R3" : "R2";
        push(18'h05555, 8'hAA, t);
        push(18'h02AAA, 8'h55, t);
        push(18'h05555, 8'h80, t);
        push(18'h05555, 8'hAA, t);
        push(18'h02AAA, 8'h55, t);
        if (sect) push(a, 8'h30, t);
        else      push(18'h05555, 8'h10, t);
    endtask

    // Flash model state (written only by the model process).
    logic [7:0]    mem [16];
    int            busy = 0;
    bit            stale = 0;
    bit            tog = 0;
    bit            prog_mode = 0;
    bit            seen80 = 0;
    bit            addr_bad = 0;
    int            busy_reads = 0;
    logic [AW-1:0] poll_addr = '0;
    logic [7:0]    last_d = 8'h00;
    logic [7:0]    prev_d = 8'h00;
    bit            pwe = 1, poe = 1, wbad = 0;
    int            wlow = 0;
    logic [AW-1:0] fall_a = '0;
    int            seen_gen = 0;

    // Bench controls for the model (written only by the stimulus).
    int busy_len = 3;
    int gen = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = 8'hFF;

    // Model and monitor, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (seen_gen != gen) begin
            seen_gen = gen; busy = 0; stale = 0; addr_bad = 0; busy_reads = 0;
        end
        if (rst_n) begin
            if (pwe && !fl_we_n) begin fall_a = fl_addr; wlow = 0; wbad = 0; end
            if (!fl_we_n) begin
                wlow++;
                if (fl_oe_n !== 1'b1 || fl_dq_oe !== 1'b1 || fl_addr !== fall_a) wbad = 1;
            end
            if (!pwe && fl_we_n) begin
                chk(wlow >= WL && !wbad && fl_addr == fall_a, "R4 write timing", 32'(wlow), 32'(WL));
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected write", {14'd0, fl_addr}, 0);
                end else begin
                    wr_t w;
                    w = exp_q.pop_front();
                    chk(fl_addr == w.a && fl_dq_o == w.d, w.tag, {6'd0, fl_addr, fl_dq_o}, {6'd0, w.a, w.d});
                end
                if (prev_d == 8'hA0 && busy == 0) begin
                    mem[fl_addr[3:0]] = mem[fl_addr[3:0]] & fl_dq_o;
                    last_d = fl_dq_o; poll_addr = fl_addr; prog_mode = 1; busy = busy_len;
                end else if (seen80 && (fl_dq_o == 8'h10 || fl_dq_o == 8'h30)) begin
                    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
                    seen80 = 0; prog_mode = 0; poll_addr = fl_addr; busy = busy_len;
                end
                if (fl_dq_o == 8'h80) seen80 = 1;
                prev_d = fl_dq_o;
            end
            if (poe && !fl_oe_n) begin
                if (prog_mode && (busy > 0 || stale) && fl_addr != poll_addr) addr_bad = 1;
                if (busy > 0) begin
                    rd_val = {prog_mode ? ~last_d[7] : 1'b0, tog, 6'h15};
                    tog = ~tog; busy--; busy_reads++;
                    if (busy == 0) stale = 1;
                end else if (stale) begin
                    rd_val = {mem[fl_addr[3:0]][7], tog, ~mem[fl_addr[3:0]][5:0]};
                    stale = 0;
                end else begin
                    rd_val = mem[fl_addr[3:0]];
                end
            end
        end
        pwe = fl_we_n;
        poe = fl_oe_n;
    end

    bit wd_hit = 0;
    logic got_err;
    logic [7:0] got_byte;

    task automatic run_req(input logic [1:0] op, input bit tg, input logic [AW-1:0] a,
                           input logic [LW-1:0] last, input int blen);
        int n;
        busy_len = blen;
        gen++;
        @(negedge clk);
        req_op = op; req_toggle = tg; req_addr = a; req_last = last; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low while busy", 32'(req_ready), 0);
        n = 0;
        while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) begin
            wd_hit = 1;
            chk(0, "R11 watchdog, no done", 0, 1);
        end
        got_err = err;
        got_byte = done_byte;
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11 done single pulse", 32'(done), 0);
        chk(exp_q.size() == 0, "R1 all expected writes seen", 32'(exp_q.size()), 0);
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(negedge clk);
        fails++;
        $display("FAIL R11 global watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done,
            "R11 reset state", {26'd0, req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done}, 6'b111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Chip erase, DQ7 polling.
        push_erase(0, 18'h00000);
        run_req(2'd2, 0, 18'h00000, 0, 4);
        chk(got_err == 1'b0, "R6 chip erase no error", 32'(got_err), 0);
        chk(got_byte == 8'hFF, "R8 chip erase final byte", 32'(got_byte), 8'hFF);

        // Three-byte program, DQ7 polling, mixed bit 7 values.
        push_prog(18'h00100, 8'd2);
        run_req(2'd0, 0, 18'h00100, 8'd2, 3);
        chk(got_err == 1'b0, "R5 program no error", 32'(got_err), 0);
        chk(!addr_bad, "R5 poll address held", 32'(addr_bad), 0);
        chk(got_byte == pat(8'd2), "R8 R9 last programmed byte", 32'(got_byte), 32'(pat(8'd2)));

        // Sector erase, DQ6 pair polling.
        push_erase(1, 18'h3A000);
        run_req(2'd1, 1, 18'h3A000, 0, 5);
        chk(got_err == 1'b0, "R7 sector erase toggle no error", 32'(got_err), 0);
        chk(got_byte == 8'hFF, "R8 R3 sector erase final byte", 32'(got_byte), 8'hFF);

        // Single-byte program, DQ6 pair polling.
        push_prog(18'h3A005, 8'd0);
        run_req(2'd0, 1, 18'h3A005, 8'd0, 6);
        chk(got_err == 1'b0, "R7 program toggle no error", 32'(got_err), 0);
        chk(got_byte == pat(8'd0), "R8 toggle final byte", 32'(got_byte), 32'(pat(8'd0)));
        chk(!addr_bad, "R5 toggle poll address held", 32'(addr_bad), 0);

        // Program that never finishes: timeout.
        push_prog(18'h00008, 8'd0);
        run_req(2'd0, 0, 18'h00008, 8'd0, 200);
        chk(got_err == 1'b1, "R10 timeout error flag", 32'(got_err), 1);
        chk(busy_reads == PM, "R10 poll attempts before timeout", 32'(busy_reads), 32'(PM));

        // Recovery after timeout; op code 3 behaves as chip erase.
        push_prog(18'h00009, 8'd0);
        run_req(2'd0, 0, 18'h00009, 8'd0, 1);
        chk(got_err == 1'b0, "R10 recovery no error", 32'(got_err), 0);
        chk(got_byte == pat(8'd0), "R8 recovery byte", 32'(got_byte), 32'(pat(8'd0)));
        push_erase(0, 18'h00000);
        run_req(2'd3, 0, 18'h00004, 0, 2);
        chk(got_err == 1'b0 && got_byte == 8'hFF, "R2 op code 3 chip erase", 32'(got_byte), 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule